// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

The block controls one port of eight bidirectional pins. A direction register sets each pin as an input or an output. A data register holds the level that an output pin drives. On an input pin the same data bit turns on the weak pull-up. A read-only pin-input register samples the real level of every pin through a two-stage synchronizer, whatever the pin's direction. Software reaches the three registers over a simple bus. The bus has a word write, a same-cycle read, and single-bit set and clear strobes, so one pin can be reconfigured without a read-modify-write of the whole register.

Per pin, the block drives three signals to a pad wrapper: output enable, output value and pull-up enable. It takes the raw pad level back as an input. Three inputs act on the whole port. A global input removes every pull-up. A sleep input clamps the digital input of each pin to 0 before the synchronizer, so a floating pad costs no power; a pin flagged as an interrupt source is exempt from this clamp. An asynchronous reset tri-states every pin at once, with no clock needed.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The register map is: address 0 is the pin-input register, address 1 the direction register, address 2 the data register, and address 3 reads as 0. While `busRd` is 1, `busRdata` shows the addressed register in the same cycle. While `busRd` is 0, `busRdata` is 0. Reading address 2 returns the stored data bits, not the pad levels.
- R2: `padOe` equals the direction register, where bit value 1 means output. `padOut` equals the data register. A word write to address 1 shows on `padOe` right after the clock edge that takes it.
- R3: `padPullEn[i]` is 1 exactly when direction bit i is 0, data bit i is 1 and `pullDisable` is 0. An output pin never has its pull-up on.
- R4: Driving `rstN` low clears the direction, data and pin-input registers at once, without a clock edge. Every pin is then tri-stated with no pull-up.
- R5: The pad level is captured on the falling clock edge and moved into the pin-input register on the next rising edge. An external change therefore appears between half a cycle and one and a half cycles later. A level the port itself drives after a register write can be read back one cycle after that write.
- R6: While `sleepReq` is 1, the synchronizer input of every pin whose `irqEn` bit is 0 is forced to 0. Pins whose `irqEn` bit is 1 pass their pad level unchanged.
- R7: A strobe on `bitSet` or `bitClr` changes only bit `bitIdx` of the selected register, where `bitSel` 0 selects direction and 1 selects data. If both strobes are 1 in the same cycle, the bit is cleared.
- R8: In a cycle where a word write targets the register that a bit strobe selects, the word write is taken and the bit strobe is dropped. A bit strobe on the other register still applies.
- R9: Word writes to address 0 or address 3 change neither the direction register nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busRd | input | 1 | Read enable |
| busWr | input | 1 | Word write strobe |
| busWdata | input | 8 | Word write data |
| busRdata | output | 8 | Read data, combinational |
| bitSet | input | 1 | Set one bit of the selected register |
| bitClr | input | 1 | Clear one bit of the selected register |
| bitSel | input | 1 | Bit strobe target: 0 direction, 1 data |
| bitIdx | input | 3 | Bit strobe index |
| pullDisable | input | 1 | Global pull-up disable |
| sleepReq | input | 1 | Sleep input clamp request |
| irqEn | input | 8 | Per-pin exemption from the sleep clamp |
| padIn | input | 8 | Raw pad levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| padPullEn | output | 8 | Pad pull-up enables |

## Verification
On every cycle, the assertions check four things: an output pin never has its pull-up on, a bit strobe flips at most one register bit, a word write wins over a bit strobe on the same register, and writes to the pin-input and unused addresses leave the pad controls unchanged. Some behaviour only the bench scenarios can show, because it depends on the pads and on timing. These are the delay of the falling-edge capture, the readback of a driven level one cycle after a write, the sleep clamp with interrupt-source exemptions, and an asynchronous reset while the clock is running. The bench scenarios also compare every output on every cycle against a behavioural model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W = $clog2(PORT_W);
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PIN = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DAT = 2'd2;

  // Update strobes passed from the control decoder to the datapath.
  typedef struct packed {
    logic             wrDir;
    logic             wrDat;
    logic             setDir;
    logic             clrDir;
    logic             setDat;
    logic             clrDat;
    logic [IDX_W-1:0] bitIdx;
  } portStrb_t;
endpackage

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic              bitSel,
  input  logic [IDX_W-1:0]  bitIdx,
  output portStrb_t         strb
);
  logic hitDir, hitDat;
  logic selDir, selDat;

  always_comb begin
    hitDir = busWr && (busAddr == ADDR_DIR);
    hitDat = busWr && (busAddr == ADDR_DAT);
    selDir = !bitSel;
    selDat = bitSel;

    strb.wrDir  = hitDir;
    strb.wrDat  = hitDat;
    // A word write to the same register drops the bit strobe; clear beats set.
    strb.clrDir = bitClr && selDir && !hitDir;
    strb.setDir = bitSet && !bitClr && selDir && !hitDir;
    strb.clrDat = bitClr && selDat && !hitDat;
    strb.setDat = bitSet && !bitClr && selDat && !hitDat;
    strb.bitIdx = bitIdx;
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] syncOut
);
  // The first stage holds what the input showed at the falling edge, which is
  // what a latch open during the high phase would still hold at the next rise.
  logic [W-1:0] holdQ;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) holdQ <= '0;
    else       holdQ <= rawIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncOut <= '0;
    else       syncOut <= holdQ;
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrb_t         strb,
  input  logic [PORT_W-1:0] busWdata,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [PORT_W-1:0] busRdata,
  input  logic              pullDisable,
  input  logic              sleepReq,
  input  logic [PORT_W-1:0] irqEn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padPullEn
);
  logic [PORT_W-1:0] dirQ, datQ, dirD, datD;
  logic [PORT_W-1:0] gatedIn, pinQ;

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    logic hit;
    assign hit = (strb.bitIdx == IDX_W'(i));

    always_comb begin
      if (strb.wrDir)              dirD[i] = busWdata[i];
      else if (hit && strb.clrDir) dirD[i] = 1'b0;
      else if (hit && strb.setDir) dirD[i] = 1'b1;
      else                         dirD[i] = dirQ[i];

      if (strb.wrDat)              datD[i] = busWdata[i];
      else if (hit && strb.clrDat) datD[i] = 1'b0;
      else if (hit && strb.setDat) datD[i] = 1'b1;
      else                         datD[i] = datQ[i];
    end

    assign gatedIn[i] = padIn[i] & ~(sleepReq & ~irqEn[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      datQ <= '0;
    end else begin
      dirQ <= dirD;
      datQ <= datD;
    end
  end

  gpio_port_sync #(.W(PORT_W)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (gatedIn),
    .syncOut(pinQ)
  );

  assign padOe     = dirQ;
  assign padOut    = datQ;
  assign padPullEn = ~dirQ & datQ & {PORT_W{~pullDisable}};

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      unique case (busAddr)
        ADDR_PIN: busRdata = pinQ;
        ADDR_DIR: busRdata = dirQ;
        ADDR_DAT: busRdata = datQ;
        default:  busRdata = '0;
      endcase
    end
  end

  AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullEn) == '0);  // R3

  AST_SINGLE_BIT_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setDir || strb.clrDir) |=> $countones(dirQ ^ $past(dirQ)) <= 1);  // R7

  AST_SINGLE_BIT_DAT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setDat || strb.clrDat) |=> $countones(datQ ^ $past(datQ)) <= 1);  // R7

  AST_WORD_WINS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> padOe == $past(busWdata));  // R8
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic              bitSel,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              pullDisable,
  input  logic              sleepReq,
  input  logic [PORT_W-1:0] irqEn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padPullEn
);
  portStrb_t strb;

  gpio_port_ctl u_ctl (
    .busWr  (busWr),
    .busAddr(busAddr),
    .bitSet (bitSet),
    .bitClr (bitClr),
    .bitSel (bitSel),
    .bitIdx (bitIdx),
    .strb   (strb)
  );

  gpio_port_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .busRdata   (busRdata),
    .pullDisable(pullDisable),
    .sleepReq   (sleepReq),
    .irqEn      (irqEn),
    .padIn      (padIn),
    .padOe      (padOe),
    .padOut     (padOut),
    .padPullEn  (padPullEn)
  );

  AST_PIN_ADDR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_PIN || busAddr == 2'd3) && !bitSet && !bitClr)
      |=> ($stable(padOe) && $stable(padOut)));  // R9

  AST_DIR_WRITE_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_DIR) |=> padOe == $past(busWdata));  // R2
endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic       bitSet = 1'b0, bitClr = 1'b0, bitSel = 1'b0;
  logic [2:0] bitIdx = '0;
  logic       pullDisable = 1'b0, sleepReq = 1'b0;
  logic [7:0] irqEn = '0;
  logic [7:0] padIn, padOe, padOut, padPullEn;
  logic [7:0] extEn = '0, extVal = '0;

  int checks = 0;
  int failures = 0;
  bit started = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Pad model: a driven pad wins, then an external driver, then the pull-up; otherwise 0.
  for (genvar i = 0; i < 8; i++) begin : g_pad
    assign padIn[i] = padOe[i] ? padOut[i] : extEn[i] ? extVal[i] : padPullEn[i];
  end

  gpio_port_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .bitSet(bitSet), .bitClr(bitClr),
    .bitSel(bitSel), .bitIdx(bitIdx), .pullDisable(pullDisable), .sleepReq(sleepReq),
    .irqEn(irqEn), .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  // Behavioural reference model
  logic [7:0] mDir, mDat, mHold, mPin;

  function automatic logic [7:0] mPad();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      if (mDir[i])                       v[i] = mDat[i];
      else if (extEn[i])                 v[i] = extVal[i];
      else if (mDat[i] && !pullDisable)  v[i] = 1'b1;
      else                               v[i] = 1'b0;
      if (sleepReq && !irqEn[i])         v[i] = 1'b0;
    end
    return v;
  endfunction

  always @(negedge clk or negedge rstN) begin
    if (!rstN) mHold <= '0;
    else       mHold <= mPad();
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir <= '0; mDat <= '0; mPin <= '0;
    end else begin
      logic [7:0] nd, nt;
      nd = mDir; nt = mDat;
      mPin <= mHold;
      if (busWr && busAddr == 2'd1) nd = busWdata;
      else if (!bitSel && bitClr)   nd[bitIdx] = 1'b0;
      else if (!bitSel && bitSet)   nd[bitIdx] = 1'b1;
      if (busWr && busAddr == 2'd2) nt = busWdata;
      else if (bitSel && bitClr)    nt[bitIdx] = 1'b0;
      else if (bitSel && bitSet)    nt[bitIdx] = 1'b1;
      mDir <= nd; mDat <= nt;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(posedge clk) begin
    #8;
    if (started && rstN) begin
      logic [7:0] expRd;
      chk("R2 padOe", padOe, mDir);
      chk("R2 padOut", padOut, mDat);
      chk("R3 padPullEn", padPullEn, ~mDir & mDat & {8{~pullDisable}});
      if (!busRd)               expRd = '0;
      else if (busAddr == 2'd0) expRd = mPin;
      else if (busAddr == 2'd1) expRd = mDir;
      else if (busAddr == 2'd2) expRd = mDat;
      else                      expRd = '0;
      chk("R1 busRdata", busRdata, expRd);
    end
  end

  task automatic step();
    @(posedge clk); #5;
    busWr = 0; busRd = 0; bitSet = 0; bitClr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busWr = 1; busAddr = a; busWdata = d; step();
  endtask

  task automatic bitOp(input logic sel, input logic [2:0] idx, input logic s, input logic c);
    bitSel = sel; bitIdx = idx; bitSet = s; bitClr = c; step();
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [7:0] exp);
    busRd = 1; busAddr = a; #1;
    chk(req, busRdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5; rstN = 1; started = 1;
    // R4 reset state
    rdChk("R4 dir after reset", 2'd1, 8'h00);
    rdChk("R4 data after reset", 2'd2, 8'h00);
    chk("R4 padOe after reset", padOe, 8'h00);
    step();

    // R2, R3 configuration
    wr(2'd1, 8'h0F);
    chk("R2 oe after dir write", padOe, 8'h0F);
    wr(2'd2, 8'hC3);
    chk("R2 out", padOut, 8'hC3);
    chk("R3 pulls on inputs only", padPullEn, 8'hC0);
    // R5 readback of driven level: old value now, new one cycle later
    rdChk("R5 pin before settle", 2'd0, 8'h00);
    step();
    rdChk("R5 pin readback", 2'd0, 8'hC3);
    rdChk("R1 data reads register", 2'd2, 8'hC3);
    step();

    // R5 external change on input pins 4,5
    extEn = 8'h30; extVal = 8'h10;
    rdChk("R5 external not yet seen", 2'd0, 8'hC3);
    step();
    rdChk("R5 external seen", 2'd0, 8'hD3);
    step();
    pullDisable = 1; #1;
    chk("R3 global disable", padPullEn, 8'h00);
    step(); pullDisable = 0;
    step();

    // R7 bit operations
    bitOp(1'b0, 3'd7, 1, 0);
    rdChk("R7 set dir bit 7", 2'd1, 8'h8F);
    step();
    bitOp(1'b1, 3'd0, 0, 1);
    rdChk("R7 clear data bit 0", 2'd2, 8'hC2);
    step();
    bitOp(1'b1, 3'd1, 1, 1);
    rdChk("R7 clear wins over set", 2'd2, 8'hC0);
    step();

    // R8 word write priority
    busWr = 1; busAddr = 2'd1; busWdata = 8'h55; bitSel = 0; bitIdx = 3'd1; bitSet = 1; step();
    rdChk("R8 word write wins", 2'd1, 8'h55);
    step();
    busWr = 1; busAddr = 2'd2; busWdata = 8'h3C; bitSel = 0; bitIdx = 3'd7; bitSet = 1; step();
    rdChk("R8 other register bit op applies", 2'd1, 8'hD5);
    rdChk("R8 data word written", 2'd2, 8'h3C);
    step();

    // R9 ignored writes
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'hAA);
    rdChk("R9 dir unchanged", 2'd1, 8'hD5);
    rdChk("R9 data unchanged", 2'd2, 8'h3C);
    step();

    // R6 sleep clamp
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    extEn = 8'hFF; extVal = 8'hFF; irqEn = 8'h0F; sleepReq = 1;
    step(); step();
    rdChk("R6 clamp except irq pins", 2'd0, 8'h0F);
    step();
    sleepReq = 0;
    step(); step();
    rdChk("R6 clamp released", 2'd0, 8'hFF);
    rdChk("R1 unused address", 2'd3, 8'h00);
    step();

    // R4 asynchronous reset while running
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'hFF);
    rstN = 0; #1;
    chk("R4 async oe clear", padOe, 8'h00);
    chk("R4 async pull clear", padPullEn, 8'h00);
    rdChk("R4 async pin clear", 2'd0, 8'h00);
    step();
    rstN = 1;
    step(); step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule